// File: doc/BRIEF.md
# Loop Branch Evaluator

This block settles the small-loop branch that can ride on any arithmetic instruction. A 3-bit condition digit and a 3-bit distance digit, taken from the loop-control field of the instruction, decide one of two outcomes. The program either steps to the next instruction, or it jumps back by the distance, counted in instructions. A loop can therefore close without a separate branch instruction. Depending on the condition code, the same step can also decrement an index register and test it, test the accumulator, or clear the overflow indicator.

The sequencer pulses `evalValid` for one cycle. In that cycle it presents the loop-control field, the accumulator, the index register already fetched for the tag digit, and the current program counter. One clock later the block returns the registered result: the next program counter, a decrement strobe with the decremented index value to write back, and an overflow-clear strobe. The sequencer fetches the index register and performs the instruction's main operation; both lie outside this block.

Top module: `loop_branch_eval`

## Requirements
- R1: While `rstN` is low, and at the first edge after release, every output is zero.
- R2: `outValid` is high in the cycle after each clock edge that sees `evalValid` high, and low otherwise. All strobes and `jumpTaken` are low whenever `outValid` is low.
- R3: Condition code 0 never jumps. `ovfClearStrobe` is raised exactly when the distance digit is odd (bit 0 of the distance set).
- R4: Condition code 1 always raises `idxDecStrobe` with `idxNewValue` equal to the index minus 1, modulo 2^WORD_W. It jumps back exactly when the index value before the decrement is nonzero.
- R5: Condition code 2 raises `idxDecStrobe` with the index minus 1 and never jumps.
- R6: Codes 3 to 7 test the accumulator as a two's-complement number whose sign is its top bit. The jump conditions are: 3 for value >= 0, 4 for value > 0, 5 for value nonzero, 6 for value zero, and 7 for value < 0.
- R7: When a jump is taken, `nextPc` is the current counter minus the distance, modulo 2^PC_W, so a distance of 0 targets the same instruction.
- R8: When no jump is taken, `nextPc` is the current counter plus one, modulo 2^PC_W.
- R9: `ovfClearStrobe` occurs only for code 0, and `idxDecStrobe` occurs only for codes 1 and 2.
- R10: A cycle without `evalValid` leaves `nextPc` and `idxNewValue` unchanged.
- R11: The loop-control field carries the condition digit in bits 2:0 and the distance digit in bits 5:3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evalValid | input | 1 | Evaluate the presented operands this cycle |
| loopField | input | 2*DIG_W (6) | Condition digit [2:0], distance digit [5:3] |
| accValue | input | WORD_W (30) | Accumulator contents |
| indexValue | input | WORD_W (30) | Index register selected by the tag digit |
| pcCur | input | PC_W (14) | Program counter of the current instruction |
| outValid | output | 1 | Result registers hold a fresh evaluation |
| nextPc | output | PC_W (14) | Next program counter |
| jumpTaken | output | 1 | The loop branch was taken |
| idxDecStrobe | output | 1 | Write `idxNewValue` back to the index register |
| idxNewValue | output | WORD_W (30) | Index value minus one |
| ovfClearStrobe | output | 1 | Clear the overflow indicator |

## Verification
The bench builds the block with its default parameters: a 30-bit word, a 14-bit counter and 3-bit digits. At these values the sign bit sits at bit 29, so the accumulator tests can be driven at the most negative and most positive words, at zero and at ±1. The 14-bit counter lets both wraps be reached: a backward jump from address 0 and a forward step from 16383. An index of zero under code 1 exercises the decrement that wraps to all ones while the loop falls through.

// File: rtl/loop_branch_pkg.sv
package loop_branch_pkg;

  typedef enum logic [2:0] {
    COND_NONE     = 3'd0,
    COND_IDX_LOOP = 3'd1,
    COND_IDX_DEC  = 3'd2,
    COND_ACC_GE   = 3'd3,
    COND_ACC_GT   = 3'd4,
    COND_ACC_NZ   = 3'd5,
    COND_ACC_EZ   = 3'd6,
    COND_ACC_LT   = 3'd7
  } condCode_e;

  typedef struct packed {
    logic doJump;
    logic doDec;
    logic doClear;
  } loopCtrl_t;

endpackage

// File: rtl/loop_branch_ctrl.sv
module loop_branch_ctrl
  import loop_branch_pkg::*;
#(
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        condDigit,
  input  logic              distOdd,
  input  logic [WORD_W-1:0] accValue,
  input  logic [WORD_W-1:0] indexValue,
  output loopCtrl_t         ctrl
);

  localparam int SIGN_BIT = WORD_W - 1;

  logic accSign;
  logic accZero;
  logic idxZero;

  assign accSign = accValue[SIGN_BIT];
  assign accZero = (accValue == '0);
  assign idxZero = (indexValue == '0);

  always_comb begin
    ctrl = '0;
    unique case (condCode_e'(condDigit))
      COND_NONE:     ctrl.doClear = distOdd;
      COND_IDX_LOOP: begin
        ctrl.doDec  = 1'b1;
        ctrl.doJump = !idxZero;
      end
      COND_IDX_DEC:  ctrl.doDec  = 1'b1;
      COND_ACC_GE:   ctrl.doJump = !accSign;
      COND_ACC_GT:   ctrl.doJump = !accSign && !accZero;
      COND_ACC_NZ:   ctrl.doJump = !accZero;
      COND_ACC_EZ:   ctrl.doJump = accZero;
      COND_ACC_LT:   ctrl.doJump = accSign;
      default:       ctrl = '0;
    endcase
  end

  // clear request only from the no-jump code
  assert_clear_code_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.doClear |-> (condDigit == 3'd0));

  // decrement request only from the two index codes
  assert_dec_code_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.doDec |-> (condDigit == 3'd1 || condDigit == 3'd2));

  // a zero index under code 1 never loops
  assert_zero_index_R4: assert property (@(posedge clk) disable iff (!rstN)
    (condDigit == 3'd1 && indexValue == '0) |-> !ctrl.doJump);

endmodule

// File: rtl/loop_branch_dp.sv
module loop_branch_dp
  import loop_branch_pkg::*;
#(
  parameter int WORD_W = 30,
  parameter int PC_W   = 14,
  parameter int DIG_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalValid,
  input  loopCtrl_t         ctrl,
  input  logic [DIG_W-1:0]  distDigit,
  input  logic [PC_W-1:0]   pcCur,
  input  logic [WORD_W-1:0] indexValue,
  output logic              outValid,
  output logic [PC_W-1:0]   nextPc,
  output logic              jumpTaken,
  output logic              idxDecStrobe,
  output logic [WORD_W-1:0] idxNewValue,
  output logic              ovfClearStrobe
);

  localparam int PAD_W = PC_W - DIG_W;

  logic [PC_W-1:0]   distWide;
  logic [PC_W-1:0]   pcBack;
  logic [PC_W-1:0]   pcStep;
  logic [PC_W-1:0]   pcSel;
  logic [WORD_W-1:0] idxDec;

  assign distWide = {{PAD_W{1'b0}}, distDigit};
  assign pcBack   = pcCur - distWide;
  assign pcStep   = pcCur + PC_W'(1);
  assign pcSel    = ctrl.doJump ? pcBack : pcStep;
  assign idxDec   = indexValue - WORD_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid       <= 1'b0;
      nextPc         <= '0;
      jumpTaken      <= 1'b0;
      idxDecStrobe   <= 1'b0;
      idxNewValue    <= '0;
      ovfClearStrobe <= 1'b0;
    end else begin
      outValid       <= evalValid;
      jumpTaken      <= evalValid && ctrl.doJump;
      idxDecStrobe   <= evalValid && ctrl.doDec;
      ovfClearStrobe <= evalValid && ctrl.doClear;
      if (evalValid) begin
        nextPc      <= pcSel;
        idxNewValue <= idxDec;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    evalValid |=> outValid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rstN)
    !evalValid |=> !outValid);

  assert_strobe_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    (jumpTaken || idxDecStrobe || ovfClearStrobe) |-> outValid);

  assert_jump_target_R7: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && ctrl.doJump) |=> (nextPc == $past(pcCur) - $past(distWide)));

  assert_step_target_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && !ctrl.doJump) |=> (nextPc == $past(pcCur) + PC_W'(1)));

  assert_dec_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && ctrl.doDec) |=> (idxNewValue == $past(indexValue) - WORD_W'(1)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !evalValid |=> ($stable(nextPc) && $stable(idxNewValue)));

  assert_clear_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    ovfClearStrobe |-> (!jumpTaken && !idxDecStrobe));

endmodule

// File: rtl/loop_branch_eval.sv
module loop_branch_eval
  import loop_branch_pkg::*;
#(
  parameter int WORD_W = 30,
  parameter int PC_W   = 14,
  parameter int DIG_W  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 evalValid,
  input  logic [2*DIG_W-1:0]   loopField,
  input  logic [WORD_W-1:0]    accValue,
  input  logic [WORD_W-1:0]    indexValue,
  input  logic [PC_W-1:0]      pcCur,
  output logic                 outValid,
  output logic [PC_W-1:0]      nextPc,
  output logic                 jumpTaken,
  output logic                 idxDecStrobe,
  output logic [WORD_W-1:0]    idxNewValue,
  output logic                 ovfClearStrobe
);

  // R11: condition digit low, distance digit high
  logic [DIG_W-1:0] condDigit;
  logic [DIG_W-1:0] distDigit;
  loopCtrl_t        ctrl;

  assign condDigit = loopField[DIG_W-1:0];
  assign distDigit = loopField[2*DIG_W-1:DIG_W];

  loop_branch_ctrl #(
    .WORD_W(WORD_W)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .condDigit (condDigit[2:0]),
    .distOdd   (distDigit[0]),
    .accValue  (accValue),
    .indexValue(indexValue),
    .ctrl      (ctrl)
  );

  loop_branch_dp #(
    .WORD_W(WORD_W),
    .PC_W  (PC_W),
    .DIG_W (DIG_W)
  ) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .evalValid     (evalValid),
    .ctrl          (ctrl),
    .distDigit     (distDigit),
    .pcCur         (pcCur),
    .indexValue    (indexValue),
    .outValid      (outValid),
    .nextPc        (nextPc),
    .jumpTaken     (jumpTaken),
    .idxDecStrobe  (idxDecStrobe),
    .idxNewValue   (idxNewValue),
    .ovfClearStrobe(ovfClearStrobe)
  );

endmodule

// File: tb/test_loop_branch_eval.sv
module test_loop_branch_eval;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 30;
  localparam int PC_W   = 14;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              evalValid = 1'b0;
  logic [5:0]        loopField = '0;
  logic [WORD_W-1:0] accValue = '0;
  logic [WORD_W-1:0] indexValue = '0;
  logic [PC_W-1:0]   pcCur = '0;
  logic              outValid;
  logic [PC_W-1:0]   nextPc;
  logic              jumpTaken;
  logic              idxDecStrobe;
  logic [WORD_W-1:0] idxNewValue;
  logic              ovfClearStrobe;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_branch_eval i_loop_branch_eval (
    .clk(clk), .rstN(rstN), .evalValid(evalValid), .loopField(loopField),
    .accValue(accValue), .indexValue(indexValue), .pcCur(pcCur),
    .outValid(outValid), .nextPc(nextPc), .jumpTaken(jumpTaken),
    .idxDecStrobe(idxDecStrobe), .idxNewValue(idxNewValue),
    .ovfClearStrobe(ovfClearStrobe)
  );

  task automatic checkVal(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one evaluation, then sample after the registering edge.
  task automatic runEval(input string req, input logic [2:0] c, input logic [2:0] d,
                         input logic [WORD_W-1:0] acc, input logic [WORD_W-1:0] idx,
                         input logic [PC_W-1:0] pc);
    logic expJump, expDec, expClr;
    logic accNeg, accZ;
    logic [PC_W-1:0] expPc;
    accNeg = acc[WORD_W-1];
    accZ = (acc == 0);
    expJump = 1'b0; expDec = 1'b0; expClr = 1'b0;
    case (c)
      3'd0: expClr = d[0];
      3'd1: begin expDec = 1'b1; expJump = (idx != 0); end
      3'd2: expDec = 1'b1;
      3'd3: expJump = !accNeg;
      3'd4: expJump = !accNeg && !accZ;
      3'd5: expJump = !accZ;
      3'd6: expJump = accZ;
      default: expJump = accNeg;
    endcase
    expPc = expJump ? PC_W'(pc - PC_W'(d)) : PC_W'(pc + PC_W'(1));
    @(negedge clk);
    loopField = {d, c};
    accValue = acc;
    indexValue = idx;
    pcCur = pc;
    evalValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    evalValid = 1'b0;
    checkVal(req, "outValid R2", 32'(outValid), 32'd1);
    checkVal(req, "jumpTaken", 32'(jumpTaken), 32'(expJump));
    checkVal(req, "nextPc", 32'(nextPc), 32'(expPc));
    checkVal(req, "idxDecStrobe R9", 32'(idxDecStrobe), 32'(expDec));
    checkVal(req, "ovfClearStrobe R9", 32'(ovfClearStrobe), 32'(expClr));
    if (expDec) checkVal(req, "idxNewValue", 32'(idxNewValue), 32'(WORD_W'(idx - 1)));
  endtask

  task automatic testReset();
    checkVal("R1", "outValid", 32'(outValid), 32'd0);
    checkVal("R1", "nextPc", 32'(nextPc), 32'd0);
    checkVal("R1", "strobes", 32'({jumpTaken, idxDecStrobe, ovfClearStrobe}), 32'd0);
    checkVal("R1", "idxNewValue", 32'(idxNewValue), 32'd0);
  endtask

  task automatic testNoJumpCode();
    runEval("R3", 3'd0, 3'd0, 30'd5, 30'd9, 14'd100);
    runEval("R3", 3'd0, 3'd3, 30'd0, 30'd9, 14'd100);
    runEval("R3", 3'd0, 3'd7, 30'h2000_0000, 30'd0, 14'd7);
    runEval("R3", 3'd0, 3'd6, 30'd1, 30'd1, 14'd7);
  endtask

  task automatic testIndexCodes();
    runEval("R4", 3'd1, 3'd4, 30'd0, 30'd3, 14'd50);
    runEval("R4", 3'd1, 3'd4, 30'd0, 30'd1, 14'd50);
    runEval("R4", 3'd1, 3'd4, 30'd0, 30'd0, 14'd50);
    runEval("R5", 3'd2, 3'd5, 30'd0, 30'd12, 14'd60);
    runEval("R5", 3'd2, 3'd1, 30'h3FFF_FFFF, 30'd0, 14'd60);
  endtask

  task automatic testAccCodes();
    logic [WORD_W-1:0] vals [5] = '{30'd0, 30'd1, 30'h3FFF_FFFF, 30'h2000_0000, 30'h1FFF_FFFF};
    for (int code = 3; code <= 7; code++) begin
      for (int k = 0; k < 5; k++) begin
        runEval("R6", 3'(code), 3'd2, vals[k], 30'd4, 14'd200);
      end
    end
  endtask

  task automatic testWrap();
    runEval("R7", 3'd5, 3'd3, 30'd8, 30'd0, 14'd1);
    runEval("R7", 3'd5, 3'd0, 30'd8, 30'd0, 14'd333);
    runEval("R7", 3'd6, 3'd7, 30'd0, 30'd0, 14'd0);
    runEval("R8", 3'd6, 3'd7, 30'd8, 30'd0, 14'h3FFF);
  endtask

  task automatic testField();
    // R11: field 6'b010_011 is distance 2, condition 3
    runEval("R11", 3'd3, 3'd2, 30'd0, 30'd0, 14'd10);
    checkVal("R11", "nextPc target", 32'(nextPc), 32'd8);
  endtask

  task automatic testHold();
    logic [PC_W-1:0] keptPc;
    logic [WORD_W-1:0] keptIdx;
    runEval("R10", 3'd1, 3'd2, 30'd0, 30'd77, 14'd900);
    keptPc = nextPc;
    keptIdx = idxNewValue;
    @(negedge clk);
    loopField = {3'd1, 3'd1};
    indexValue = 30'd5;
    pcCur = 14'd3;
    @(posedge clk);
    @(negedge clk);
    checkVal("R10", "nextPc held", 32'(nextPc), 32'(keptPc));
    checkVal("R10", "idxNewValue held", 32'(idxNewValue), 32'(keptIdx));
    checkVal("R2", "outValid idle", 32'(outValid), 32'd0);
    checkVal("R2", "strobes idle", 32'({jumpTaken, idxDecStrobe, ovfClearStrobe}), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    testReset();
    testNoJumpCode();
    testIndexCodes();
    testAccCodes();
    testWrap();
    testField();
    testHold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule